// File: doc/BRIEF.md
# Programmable Local Bus Data-Drive Timer

This block decides, cycle by cycle, when a bridge drives its local data pins and when it lets them float. Each local bus transaction begins with a one-cycle start strobe, called the reference cycle. An internal phase counter then counts clocks from that point. Four programmable cycle offsets set the drive window. Two of them apply to write transactions and two apply to read transactions.

A single 32-bit control word holds these offsets, plus three control bits. The control bits set the local reset pin, gate the local clock, and select between Intel-style and Motorola-style strobes. If any offset is set beyond the supported range, the block cannot finish a transaction inside its 16-clock budget. In that case every start strobe is answered with a retry request and no drive window opens. A build-time variant option changes two reset defaults: the read re-drive offset and one fixed size code in the read-only field.

Top module: `lbus_drive_timer`

## Requirements
- R1: After reset, the control word reads 0x022004F0 in the default variant. Its fields are: write drive-start 0 in bits 3:0, write float 0xF in bits 7:4, read re-drive 4 in bits 11:8, read release 0 in bits 15:12, code 010 in bits 22:20 and code 010 in bits 26:24, with bits 31:29 all 0. `data_oe` is 0 after reset.
- R2: The phase counter is 0 in the cycle after an accepted start strobe. For a write (`xact_is_read`=0), `data_oe` is 1 exactly for phase counts k with drive-start ≤ k < float.
- R3: For a read (`xact_is_read`=1), `data_oe` is 1 exactly for counts k < 15 with k < release or k ≥ re-drive.
- R4: If the float offset is ≤ the drive offset for the current direction (write float ≤ write drive-start, or read re-drive ≤ read release), `data_oe` stays 0 for the whole transaction.
- R5: If any of the four offsets is above 10, `retry_req` is 1 in the same cycle as `xact_start`, and the transaction is not started (`data_oe` stays 0). When all four offsets are ≤ 10, `retry_req` stays 0.
- R6: The phase counter saturates at 15. `data_oe` is 0 at count 15 and while idle, until the next accepted start.
- R7: `lrst_out` is 1 while the host reset `rst_n` is low, and whenever bit 29 of the control word is 1. Otherwise it is 0.
- R8: With bit 30 set to 1, `lclk_out` follows `clk`. With bit 30 set to 0, `lclk_out` is held low. A change of bit 30 takes effect at a falling edge of `clk`.
- R9: Bit 31 drives `motorola_sel` (0 = Intel-style, 1 = Motorola-style). While `mode_sel` is 01, both bit 31 and `motorola_sel` read 0, and writes to bit 31 are ignored.
- R10: Bits 28:16 are read-only and keep their fixed values regardless of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Host reset, active low, asynchronous |
| mode_sel | input | 2 | Bridge mode; value 01 forces Intel-style strobes |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Control word read-back |
| xact_start | input | 1 | Reference-cycle strobe that starts a transaction |
| xact_is_read | input | 1 | Direction, sampled with `xact_start` (1 = read) |
| data_oe | output | 1 | Local data bus output enable |
| retry_req | output | 1 | Retry request for a start that cannot be served |
| lclk_out | output | 1 | Gated local clock |
| lrst_out | output | 1 | Local bus reset pin, active high |
| motorola_sel | output | 1 | Strobe-style select |

## Verification
The assertions assume that `xact_start` is a single-cycle pulse. They also assume the offset fields are not rewritten while a transaction window is open, because the contention checks compare against the fields as they currently read back. The checker tracks its own window counter, which it restarts only on starts that were not retried. The stimulus follows these rules: each start is spaced more than 16 cycles from the previous one, and every control word write and `mode_sel` change waits until the scoreboard has drained the previous transaction's expected enables.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

   // control word bit positions that the surrounding bridge decodes
   localparam int unsigned RO_LO     = 16;
   localparam int unsigned RO_HI     = 28;
   localparam int unsigned BAR0_LSB  = 20;
   localparam int unsigned BAR1_LSB  = 24;
   localparam int unsigned SWRST_BIT = 29;
   localparam int unsigned CLKEN_BIT = 30;
   localparam int unsigned STYLE_BIT = 31;

   localparam logic [2:0] SIZE_4B = 3'b001;
   localparam logic [2:0] SIZE_8B = 3'b010;

   localparam logic [1:0] MODE_FORCE_INTEL = 2'b01;

   typedef enum logic {
      DIR_WR = 1'b0,
      DIR_RD = 1'b1
   } xact_dir_e;

endpackage

// File: rtl/lbt_cfg_reg.sv
module lbt_cfg_reg
   import lbt_pkg::*;
#(
   parameter int unsigned OFS_W   = 4,
   parameter bit          PARPORT = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [31:0]          wr_data,
   input  logic [1:0]           mode_sel,
   output logic [31:0]          rd_data,
   output logic [4*OFS_W-1:0]   ofs,
   output logic                 swrst,
   output logic                 clken,
   output logic                 style
);

   localparam int unsigned OFS_BITS = 4 * OFS_W;

   logic [OFS_W-1:0]    rdrv_rst;
   logic [2:0]          bar1_code;
   logic [OFS_BITS-1:0] ofs_rst;
   logic [OFS_BITS-1:0] ofs_q;
   logic                swrst_q, clken_q, style_q;
   logic                force_intel;
   logic                unused_wr_bits;

   generate
      if (PARPORT) begin : g_parport
         assign rdrv_rst  = OFS_W'(2);
         assign bar1_code = SIZE_4B;
      end else begin : g_generic
         assign rdrv_rst  = OFS_W'(4);
         assign bar1_code = SIZE_8B;
      end
   endgenerate

   // field order from bit 0: write drive, write float, read re-drive, read release
   assign ofs_rst = {{OFS_W{1'b0}}, rdrv_rst, {OFS_W{1'b1}}, {OFS_W{1'b0}}};

   assign force_intel    = (mode_sel == MODE_FORCE_INTEL);
   assign unused_wr_bits = ^wr_data[RO_HI:OFS_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q   <= ofs_rst;
         swrst_q <= 1'b0;
         clken_q <= 1'b0;
         style_q <= 1'b0;
      end else if (wr_en) begin
         ofs_q   <= wr_data[OFS_BITS-1:0];
         swrst_q <= wr_data[SWRST_BIT];
         clken_q <= wr_data[CLKEN_BIT];
         if (!force_intel) style_q <= wr_data[STYLE_BIT];
      end
   end

   assign ofs   = ofs_q;
   assign swrst = swrst_q;
   assign clken = clken_q;
   assign style = style_q & ~force_intel;

   always_comb begin
      rd_data                  = '0;
      rd_data[OFS_BITS-1:0]    = ofs_q;
      rd_data[BAR0_LSB +: 3]   = SIZE_8B;
      rd_data[BAR1_LSB +: 3]   = bar1_code;
      rd_data[SWRST_BIT]       = swrst_q;
      rd_data[CLKEN_BIT]       = clken_q;
      rd_data[STYLE_BIT]       = style;
   end

endmodule

// File: rtl/lbt_phase_cnt.sv
module lbt_phase_cnt
   import lbt_pkg::*;
#(
   parameter int unsigned OFS_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_read,
   output logic [OFS_W-1:0] cnt,
   output xact_dir_e        dir,
   output logic             live
);

   localparam logic [OFS_W-1:0] CNT_MAX = '1;

   logic [OFS_W-1:0] cnt_q;
   xact_dir_e        dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_MAX;
         dir_q <= DIR_WR;
      end else if (start) begin
         cnt_q <= '0;
         dir_q <= is_read ? DIR_RD : DIR_WR;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt  = cnt_q;
   assign dir  = dir_q;
   assign live = (cnt_q != CNT_MAX);

endmodule

// File: rtl/lbt_oe_decode.sv
module lbt_oe_decode
   import lbt_pkg::*;
#(
   parameter int unsigned OFS_W     = 4,
   parameter int unsigned OFS_LIMIT = 10
) (
   input  logic [OFS_W-1:0]   cnt,
   input  xact_dir_e          dir,
   input  logic               live,
   input  logic [4*OFS_W-1:0] ofs,
   output logic               oe,
   output logic               bad_cfg
);

   localparam logic [OFS_W-1:0] LIMIT = OFS_W'(OFS_LIMIT);

   logic [3:0]       fld_bad;
   logic [OFS_W-1:0] wr_on, wr_off, rd_on, rd_off;
   logic             wr_win, rd_win;

   genvar gi;
   generate
      for (gi = 0; gi < 4; gi++) begin : g_fld
         assign fld_bad[gi] = ofs[gi*OFS_W +: OFS_W] > LIMIT;
      end
   endgenerate

   assign bad_cfg = |fld_bad;

   assign wr_on  = ofs[0*OFS_W +: OFS_W];
   assign wr_off = ofs[1*OFS_W +: OFS_W];
   assign rd_on  = ofs[2*OFS_W +: OFS_W];
   assign rd_off = ofs[3*OFS_W +: OFS_W];

   // an empty or inverted window never drives
   assign wr_win = (wr_off > wr_on) && (cnt >= wr_on) && (cnt < wr_off);
   assign rd_win = (rd_on > rd_off) && ((cnt < rd_off) || (cnt >= rd_on));

   assign oe = live && ((dir == DIR_WR) ? wr_win : rd_win);

endmodule

// File: rtl/lbt_clk_gate.sv
module lbt_clk_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic gclk
);

   logic en_lo;

   // enable retimed on the falling edge so the AND cannot glitch
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_lo <= 1'b0;
      else        en_lo <= en;
   end

   assign gclk = clk & en_lo;

endmodule

// File: rtl/lbus_drive_timer.sv
module lbus_drive_timer
   import lbt_pkg::*;
#(
   parameter int unsigned OFS_W     = 4,
   parameter int unsigned OFS_LIMIT = 10,
   parameter bit          PARPORT   = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  mode_sel,
   input  logic        cfg_wr_en,
   input  logic [31:0] cfg_wr_data,
   output logic [31:0] cfg_rd_data,
   input  logic        xact_start,
   input  logic        xact_is_read,
   output logic        data_oe,
   output logic        retry_req,
   output logic        lclk_out,
   output logic        lrst_out,
   output logic        motorola_sel
);

   generate
      if (OFS_W < 4 || 4 * OFS_W > RO_LO) begin : g_bad_width
         $error("lbus_drive_timer: four offset fields must fit below bit 16");
      end
      if (OFS_LIMIT >= (2 ** OFS_W) - 1) begin : g_bad_limit
         $error("lbus_drive_timer: offset limit must stay below counter saturation");
      end
   endgenerate

   logic [4*OFS_W-1:0] ofs;
   logic               swrst, clken, bad_cfg, accept, live;
   logic [OFS_W-1:0]   cnt;
   xact_dir_e          dir;

   lbt_cfg_reg #(.OFS_W(OFS_W), .PARPORT(PARPORT)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_data (cfg_wr_data),
      .mode_sel(mode_sel),
      .rd_data (cfg_rd_data),
      .ofs     (ofs),
      .swrst   (swrst),
      .clken   (clken),
      .style   (motorola_sel)
   );

   assign accept    = xact_start & ~bad_cfg;
   assign retry_req = xact_start &  bad_cfg;

   lbt_phase_cnt #(.OFS_W(OFS_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .is_read(xact_is_read),
      .cnt    (cnt),
      .dir    (dir),
      .live   (live)
   );

   lbt_oe_decode #(.OFS_W(OFS_W), .OFS_LIMIT(OFS_LIMIT)) u_dec (
      .cnt    (cnt),
      .dir    (dir),
      .live   (live),
      .ofs    (ofs),
      .oe     (data_oe),
      .bad_cfg(bad_cfg)
   );

   lbt_clk_gate u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (clken),
      .gclk (lclk_out)
   );

   assign lrst_out = ~rst_n | swrst;

endmodule

// File: rtl/lbus_drive_timer_chk.sv
module lbus_drive_timer_chk #(
   parameter int unsigned OFS_W     = 4,
   parameter int unsigned OFS_LIMIT = 10
) (
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  mode_sel,
   input logic [31:0] cfg_rd_data,
   input logic        xact_start,
   input logic        xact_is_read,
   input logic        data_oe,
   input logic        retry_req,
   input logic        lclk_out,
   input logic        lrst_out,
   input logic        motorola_sel
);

   localparam logic [OFS_W-1:0] W_MAX = '1;
   localparam logic [OFS_W-1:0] LIM   = OFS_W'(OFS_LIMIT);

   logic [OFS_W-1:0] w_cnt;
   logic             w_rd;
   logic [OFS_W-1:0] f_wdrv, f_wflt, f_rdrv, f_rrel;
   logic             f_bad;

   assign f_wdrv = cfg_rd_data[0*OFS_W +: OFS_W];
   assign f_wflt = cfg_rd_data[1*OFS_W +: OFS_W];
   assign f_rdrv = cfg_rd_data[2*OFS_W +: OFS_W];
   assign f_rrel = cfg_rd_data[3*OFS_W +: OFS_W];
   assign f_bad  = (f_wdrv > LIM) || (f_wflt > LIM) || (f_rdrv > LIM) || (f_rrel > LIM);

   // window tracker driven only by starts that were not retried
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_cnt <= W_MAX;
         w_rd  <= 1'b0;
      end else if (xact_start && !retry_req) begin
         w_cnt <= '0;
         w_rd  <= xact_is_read;
      end else if (w_cnt != W_MAX) begin
         w_cnt <= w_cnt + 1'b1;
      end
   end

   AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (w_cnt != W_MAX)); // R6
   AST_WR_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      (!w_rd && (f_wflt <= f_wdrv)) |-> !data_oe); // R4
   AST_RD_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
      (w_rd && (f_rdrv <= f_rrel)) |-> !data_oe); // R4
   AST_RETRY_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (xact_start && f_bad) |-> retry_req); // R5
   AST_NO_RETRY_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      !f_bad |-> !retry_req); // R5
   AST_SWRST_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_data[29] |-> lrst_out); // R7
   AST_INTEL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 2'b01) |-> (!motorola_sel && !cfg_rd_data[31])); // R9
   AST_RO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(cfg_rd_data[28:16])); // R10
   AST_LCLK_GATED: assert property (@(negedge clk) disable iff (!rst_n)
      $stable(cfg_rd_data[30]) |-> (lclk_out == cfg_rd_data[30])); // R8

endmodule

bind lbus_drive_timer lbus_drive_timer_chk #(.OFS_W(OFS_W), .OFS_LIMIT(OFS_LIMIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_sel    (mode_sel),
   .cfg_rd_data (cfg_rd_data),
   .xact_start  (xact_start),
   .xact_is_read(xact_is_read),
   .data_oe     (data_oe),
   .retry_req   (retry_req),
   .lclk_out    (lclk_out),
   .lrst_out    (lrst_out),
   .motorola_sel(motorola_sel)
);

// File: tb/lbus_drive_timer_bench.sv
`timescale 1ns/1ps
module lbus_drive_timer_bench;

   typedef struct {
      logic  exp;
      int    k;
      string req;
   } sb_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_sel = 2'b00;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_wr_data = '0;
   logic [31:0] cfg_rd_data;
   logic        xact_start = 1'b0;
   logic        xact_is_read = 1'b0;
   logic        data_oe, retry_req, lclk_out, lrst_out, motorola_sel;

   int          n_chk = 0;
   int          n_err = 0;
   logic [31:0] cur_cfg = 32'h0000_04F0;
   sb_item_t    sb[$];

   always #2.5 clk = ~clk;

   lbus_drive_timer u_lbus_drive_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_sel    (mode_sel),
      .cfg_wr_en   (cfg_wr_en),
      .cfg_wr_data (cfg_wr_data),
      .cfg_rd_data (cfg_rd_data),
      .xact_start  (xact_start),
      .xact_is_read(xact_is_read),
      .data_oe     (data_oe),
      .retry_req   (retry_req),
      .lclk_out    (lclk_out),
      .lrst_out    (lrst_out),
      .motorola_sel(motorola_sel)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic cfg_bad(input logic [31:0] c);
      return (c[3:0] > 4'd10) || (c[7:4] > 4'd10) || (c[11:8] > 4'd10) || (c[15:12] > 4'd10);
   endfunction

   // expected enable at phase count k, from R2, R3, R4, R5, R6
   function automatic logic exp_oe(input logic rd, input int k, input logic [31:0] c);
      int wd = int'(c[3:0]);
      int wf = int'(c[7:4]);
      int rv = int'(c[11:8]);
      int rr = int'(c[15:12]);
      if (cfg_bad(c) || k >= 15) return 1'b0;
      if (!rd) return (wf > wd) && (k >= wd) && (k < wf);
      return (rv > rr) && ((k < rr) || (k >= rv));
   endfunction

   task automatic drain();
      while (sb.size() != 0) @(posedge clk);
   endtask

   task automatic cfg_write(input logic [31:0] d);
      drain();
      @(posedge clk); #1;
      cfg_wr_en   = 1'b1;
      cfg_wr_data = d;
      @(posedge clk); #1;
      cfg_wr_en   = 1'b0;
      cur_cfg     = d;
   endtask

   // driver: one start strobe, then the expected enable per phase count
   task automatic run_xact(input logic rd, input string req);
      sb_item_t it;
      drain();
      @(posedge clk); #1;
      xact_is_read = rd;
      xact_start   = 1'b1;
      #0.5;
      chk("R5 retry", {31'b0, retry_req}, {31'b0, cfg_bad(cur_cfg)});
      @(posedge clk); #1;
      xact_start = 1'b0;
      for (int k = 0; k < 16; k++) begin
         it.exp = exp_oe(rd, k, cur_cfg);
         it.k   = k;
         it.req = req;
         sb.push_back(it);
      end
      drain();
   endtask

   // monitor: samples enable at the falling edge
   always @(negedge clk) begin
      sb_item_t it;
      if (sb.size() != 0) begin
         it = sb.pop_front();
         chk($sformatf("%s oe k=%0d", it.req, it.k), {31'b0, data_oe}, {31'b0, it.exp});
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset word", cfg_rd_data, 32'h0220_04F0);
      chk("R1 reset oe", {31'b0, data_oe}, 32'd0);
      chk("R7 pin in host reset", {31'b0, lrst_out}, 32'd1);
      chk("R9 style after reset", {31'b0, motorola_sel}, 32'd0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      #1;
      chk("R7 pin released", {31'b0, lrst_out}, 32'd0);

      run_xact(1'b0, "R2 default write");
      run_xact(1'b1, "R3 default read");

      cfg_write(32'h0000_3872);
      run_xact(1'b0, "R2 window 2..6");
      run_xact(1'b1, "R3 float 3..7");

      cfg_write(32'h0000_0AA0);
      run_xact(1'b0, "R2 limit write");
      run_xact(1'b1, "R3 limit read");

      cfg_write(32'h0000_00B0);
      run_xact(1'b0, "R5 write float 11");
      cfg_write(32'h0000_B000);
      run_xact(1'b1, "R5 read release 11");

      cfg_write(32'h0000_0055);
      run_xact(1'b0, "R4 equal write");
      cfg_write(32'h0000_0039);
      run_xact(1'b0, "R4 inverted write");
      cfg_write(32'h0000_6600);
      run_xact(1'b1, "R4 equal read");

      cfg_write(32'h0000_04F0);
      run_xact(1'b0, "R6 full window");
      repeat (5) begin
         @(negedge clk); #1;
         chk("R6 idle after saturation", {31'b0, data_oe}, 32'd0);
      end

      cfg_write(32'h2000_04F0);
      chk("R7 software reset on", {31'b0, lrst_out}, 32'd1);
      cfg_write(32'h0000_04F0);
      chk("R7 software reset off", {31'b0, lrst_out}, 32'd0);

      cfg_write(32'h4000_04F0);
      @(posedge clk); @(posedge clk); #1;
      chk("R8 clock high phase", {31'b0, lclk_out}, 32'd1);
      @(negedge clk); #1;
      chk("R8 clock low phase", {31'b0, lclk_out}, 32'd0);
      cfg_write(32'h0000_04F0);
      @(posedge clk); @(posedge clk); #1;
      chk("R8 clock held low", {31'b0, lclk_out}, 32'd0);

      cfg_write(32'h8000_04F0);
      chk("R9 motorola select", {31'b0, motorola_sel}, 32'd1);
      chk("R9 bit 31 readback", {31'b0, cfg_rd_data[31]}, 32'd1);
      @(posedge clk); #1;
      mode_sel = 2'b01;
      #1;
      chk("R9 forced intel", {31'b0, motorola_sel}, 32'd0);
      mode_sel = 2'b00;
      cfg_write(32'h0000_04F0);
      @(posedge clk); #1;
      mode_sel = 2'b01;
      cfg_write(32'h8000_04F0);
      chk("R9 write ignored in mode 01", {31'b0, cfg_rd_data[31]}, 32'd0);
      @(posedge clk); #1;
      mode_sel = 2'b00;
      #1;
      chk("R9 ignored write not kept", {31'b0, motorola_sel}, 32'd0);

      cfg_write(32'h1FFF_04F0);
      chk("R10 fixed fields", cfg_rd_data, 32'h0220_04F0);
      run_xact(1'b1, "R10 read after ro write");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule